// File: doc/BRIEF.md
# Configuration Startup Status Sequencer

This block steps a programmable device through its start-up phases: a power-stabilisation interval, clearing of the configuration memory, a wait phase, an optional extra delay for devices that fetch their own configuration, configuration loading, and finally handing the I/O over to the user design. Throughout that sequence it drives two configuration-in-progress flags of opposite polarity. It also drives an open-drain, active-low init line as a pull-down enable.

The init line is shared with the outside world. The block pulls it low while it settles and clears memory. It releases the line in the wait phase and samples the resulting pad level through a two-flop synchronizer, so an external agent can keep the device waiting by holding the wire low. During loading, a data-error pulse makes the block pull the line low again and lock in an error phase until reset. When loading completes without error, every status pin is released and later inputs have no effect.

The bitstream loader, the memory-clearing engine and the pad cells are outside this block. It only sees their done and error pulses and the sampled pad level.

Top module: `startup_status_seq`

## Requirements
- R1: While the I/O have not gone active, `cfg_flags_oe_o` is 1, `cfg_hi_o` is 1 and `cfg_lo_n_o` is 0.
- R2: From reset the init pull-down (`init_pull_low_o` = 1) is held for `STAB_CYCLES` clock cycles of stabilisation. It then stays on through the clearing phase until a `clear_done` pulse arrives. After that pulse it is released on the next cycle.
- R3: In the wait phase the init pull-down is off. While the synchronized init level is low the block stays waiting, and `load_done` pulses have no effect.
- R4: The init pad level is used only after two flip-flop stages. A pad change therefore reaches the sequencer two clock edges after it occurs.
- R5: With `master_mode` = 0, the block enters loading on the first cycle in which the synchronized init level is high in the wait phase.
- R6: With `master_mode` = 1, the block spends `DELAY_CYCLES` cycles in an extra delay after the synchronized init level goes high, and only then enters loading. `load_done` during the delay has no effect.
- R7: If the synchronized init level goes low during the master delay, the block returns to waiting. The full delay restarts on the next release.
- R8: A `data_err` pulse during loading turns the init pull-down on from the next cycle. It stays on, with the flags still driven, until reset. Later `load_done` pulses are ignored.
- R9: When `data_err` and `load_done` fall in the same loading cycle, the error takes effect and the I/O do not go active.
- R10: A `load_done` pulse during loading releases all status pins from the next cycle: `cfg_flags_oe_o` = 0, `cfg_hi_o` = 0, `cfg_lo_n_o` = 1 and `init_pull_low_o` = 0. After that no input changes any output until reset.
- R11: `data_err` outside the loading phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = device fetches its own configuration (adds the extra delay) |
| clear_done | input | 1 | One-cycle pulse: configuration memory cleared |
| load_done | input | 1 | One-cycle pulse: configuration loading finished |
| data_err | input | 1 | One-cycle pulse: configuration data error seen |
| init_pad_i | input | 1 | Sampled level of the shared init wire |
| cfg_hi_o | output | 1 | Active-high configuring flag value |
| cfg_lo_n_o | output | 1 | Active-low configuring flag value |
| cfg_flags_oe_o | output | 1 | Drive enable for both flags; 0 once released |
| init_pull_low_o | output | 1 | Open-drain pull-down enable for the init wire |

## Verification
Two loading-phase events can arrive in the same clock cycle: a data error and the end of loading. The bench provokes this by pulsing both inputs on one edge while loading. It then judges that the init pull-down comes on, the flags stay driven, and a later completion pulse changes nothing. A second overlap is an external hold on the init wire during the master delay just as the delay counter nears expiry. The reference model there expects a return to waiting and a full restart of the delay, not entry into loading.

// File: rtl/startup_pkg.sv
package startup_pkg;

    typedef enum logic [2:0] {
        PH_SETTLE = 3'd0,
        PH_CLEAR  = 3'd1,
        PH_WAIT   = 3'd2,
        PH_DELAY  = 3'd3,
        PH_LOAD   = 3'd4,
        PH_FAULT  = 3'd5,
        PH_USER   = 3'd6
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   flag_hi;
        logic   flag_lo_n;
        logic   flag_oe;
        logic   init_pull;
    } seq_regs_t;

endpackage

// File: rtl/init_sync.sv
module init_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    output logic level_o
);
    typedef struct packed {
        logic stage1;
        logic stage2;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = pad_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.stage2;

    // R4: the output follows the pad with two edges of latency
    p_two_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q.stage1) |=> sync_q.stage2);

endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int unsigned STAB_CYCLES  = 16,
    parameter int unsigned DELAY_CYCLES = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int unsigned MAX_CYC = (STAB_CYCLES > DELAY_CYCLES) ? STAB_CYCLES : DELAY_CYCLES;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] STAB_INIT  = CNT_W'(STAB_CYCLES - 1);
    localparam logic [CNT_W-1:0] DELAY_INIT = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = DELAY_INIT;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= STAB_INIT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R6: an unrestarted count falls by one every cycle
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6: a restart always loads the full delay
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == DELAY_INIT));

endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
    import startup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic clear_done,
    input  logic load_done,
    input  logic data_err,
    input  logic init_level_i,
    input  logic timer_expired_i,
    output logic timer_start_o,
    output logic cfg_hi_o,
    output logic cfg_lo_n_o,
    output logic cfg_flags_oe_o,
    output logic init_pull_low_o
);
    seq_regs_t seq_d, seq_q;
    logic      start_d;

    always_comb begin
        seq_d   = seq_q;
        start_d = 1'b0;
        case (seq_q.phase)
            PH_SETTLE: if (timer_expired_i) seq_d.phase = PH_CLEAR;
            PH_CLEAR:  if (clear_done)      seq_d.phase = PH_WAIT;
            PH_WAIT: begin
                if (init_level_i) begin
                    if (master_mode) begin
                        seq_d.phase = PH_DELAY;
                        start_d     = 1'b1;
                    end else begin
                        seq_d.phase = PH_LOAD;
                    end
                end
            end
            PH_DELAY: begin
                if (!init_level_i) begin
                    seq_d.phase = PH_WAIT;
                end else if (timer_expired_i) begin
                    seq_d.phase = PH_LOAD;
                end
            end
            PH_LOAD: begin
                if (data_err) begin
                    seq_d.phase = PH_FAULT;
                end else if (load_done) begin
                    seq_d.phase = PH_USER;
                end
            end
            PH_FAULT: seq_d.phase = PH_FAULT;
            PH_USER:  seq_d.phase = PH_USER;
            default:  seq_d.phase = PH_FAULT;
        endcase

        seq_d.flag_oe   = (seq_d.phase != PH_USER);
        seq_d.flag_hi   = (seq_d.phase != PH_USER);
        seq_d.flag_lo_n = (seq_d.phase == PH_USER);
        seq_d.init_pull = (seq_d.phase == PH_SETTLE) || (seq_d.phase == PH_CLEAR) ||
                          (seq_d.phase == PH_FAULT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase     <= PH_SETTLE;
            seq_q.flag_hi   <= 1'b1;
            seq_q.flag_lo_n <= 1'b0;
            seq_q.flag_oe   <= 1'b1;
            seq_q.init_pull <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign timer_start_o   = start_d;
    assign cfg_hi_o        = seq_q.flag_hi;
    assign cfg_lo_n_o      = seq_q.flag_lo_n;
    assign cfg_flags_oe_o  = seq_q.flag_oe;
    assign init_pull_low_o = seq_q.init_pull;

    // R2: clearing holds until its done pulse
    p_clear_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_CLEAR && !clear_done) |=> (seq_q.phase == PH_CLEAR && init_pull_low_o));

    // R3: a low synchronized init keeps the block waiting
    p_hold_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_WAIT && !init_level_i) |=> (seq_q.phase == PH_WAIT));

    // R6: loading is never entered from the delay before the timer expires
    p_delay_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_DELAY && !timer_expired_i) |=> (seq_q.phase != PH_LOAD));

    // R8: the fault phase is sticky and keeps the init line low
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_FAULT) |=> (seq_q.phase == PH_FAULT && init_pull_low_o && cfg_flags_oe_o));

    // R9: a simultaneous error and completion ends in the fault phase
    p_err_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_LOAD && data_err && load_done) |=> (seq_q.phase == PH_FAULT));

    // R10: flags are released only after a completion pulse
    p_release_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_flags_oe_o) |-> $past(load_done));

    // R10: the user phase is final and drives nothing
    p_user_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_USER) |=> (seq_q.phase == PH_USER && !init_pull_low_o && !cfg_flags_oe_o));

endmodule

// File: rtl/startup_status_seq.sv
module startup_status_seq #(
    parameter int unsigned STAB_CYCLES  = 16,
    parameter int unsigned DELAY_CYCLES = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic clear_done,
    input  logic load_done,
    input  logic data_err,
    input  logic init_pad_i,
    output logic cfg_hi_o,
    output logic cfg_lo_n_o,
    output logic cfg_flags_oe_o,
    output logic init_pull_low_o
);
    logic init_level;
    logic timer_start;
    logic timer_expired;

    init_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (init_pad_i),
        .level_o (init_level)
    );

    dwell_timer #(
        .STAB_CYCLES  (STAB_CYCLES),
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (timer_start),
        .expired_o (timer_expired)
    );

    startup_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .master_mode     (master_mode),
        .clear_done      (clear_done),
        .load_done       (load_done),
        .data_err        (data_err),
        .init_level_i    (init_level),
        .timer_expired_i (timer_expired),
        .timer_start_o   (timer_start),
        .cfg_hi_o        (cfg_hi_o),
        .cfg_lo_n_o      (cfg_lo_n_o),
        .cfg_flags_oe_o  (cfg_flags_oe_o),
        .init_pull_low_o (init_pull_low_o)
    );

    // R1: whenever the flags are driven they show configuring levels
    p_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flags_oe_o |-> (cfg_hi_o && !cfg_lo_n_o));

endmodule

// File: tb/startup_status_seq_tb.sv
`timescale 1ns/1ps
module startup_status_seq_tb;

    localparam int STAB  = 5;
    localparam int DELAY = 12;

    localparam int M_SETTLE = 0;
    localparam int M_CLEAR  = 1;
    localparam int M_WAIT   = 2;
    localparam int M_DELAY  = 3;
    localparam int M_LOAD   = 4;
    localparam int M_FAULT  = 5;
    localparam int M_USER   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_mode = 1'b0;
    logic clear_done = 1'b0;
    logic load_done = 1'b0;
    logic data_err = 1'b0;
    logic ext_hold = 1'b0;
    logic init_pad;
    logic cfg_hi, cfg_lo_n, cfg_oe, init_pull;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    assign init_pad = ~init_pull & ~ext_hold;

    startup_status_seq #(.STAB_CYCLES(STAB), .DELAY_CYCLES(DELAY)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .master_mode     (master_mode),
        .clear_done      (clear_done),
        .load_done       (load_done),
        .data_err        (data_err),
        .init_pad_i      (init_pad),
        .cfg_hi_o        (cfg_hi),
        .cfg_lo_n_o      (cfg_lo_n),
        .cfg_flags_oe_o  (cfg_oe),
        .init_pull_low_o (init_pull)
    );

    // Behavioural reference: phase number, time spent, pad history queue
    int   m_ph;
    int   m_spent;
    bit   pad_hist[$];
    bit   seen_level;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph    <= M_SETTLE;
            m_spent <= 0;
            pad_hist = '{1'b0, 1'b0};
        end else begin
            seen_level = pad_hist[0];
            pad_hist.push_back(init_pad);
            void'(pad_hist.pop_front());
            if (m_ph == M_SETTLE) begin
                if (m_spent == STAB - 1) begin m_ph <= M_CLEAR; m_spent <= 0; end
                else m_spent <= m_spent + 1;
            end else if (m_ph == M_CLEAR) begin
                if (clear_done) m_ph <= M_WAIT;
            end else if (m_ph == M_WAIT) begin
                if (seen_level) begin
                    m_ph    <= master_mode ? M_DELAY : M_LOAD;
                    m_spent <= 0;
                end
            end else if (m_ph == M_DELAY) begin
                if (!seen_level) m_ph <= M_WAIT;
                else if (m_spent == DELAY - 1) m_ph <= M_LOAD;
                else m_spent <= m_spent + 1;
            end else if (m_ph == M_LOAD) begin
                if (data_err) m_ph <= M_FAULT;
                else if (load_done) m_ph <= M_USER;
            end
        end
    end

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        bit user;
        bit pull;
        user = (m_ph == M_USER);
        pull = (m_ph == M_SETTLE) || (m_ph == M_CLEAR) || (m_ph == M_FAULT);
        check(cur_tag, "flags_oe", cfg_oe, !user);
        check(cur_tag, "cfg_hi", cfg_hi, !user);
        check(cur_tag, "cfg_lo_n", cfg_lo_n, user);
        check(cur_tag, "init_pull", init_pull, pull);
    endtask

    // one cycle: compare at the falling edge, then drive the next inputs
    task automatic tick(input bit clr, input bit ld, input bit er);
        @(negedge clk);
        compare_all();
        clear_done = clr;
        load_done  = ld;
        data_err   = er;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic do_reset(input bit master);
        @(negedge clk);
        rst_n = 1'b0;
        master_mode = master;
        ext_hold = 1'b0;
        clear_done = 0; load_done = 0; data_err = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // --- slave flow, reset state and release ---
        do_reset(1'b0);
        cur_tag = "R1";
        check("R1", "reset flags_oe", cfg_oe, 1'b1);
        check("R2", "reset init_pull", init_pull, 1'b1);
        cur_tag = "R2";
        idle(STAB + 3);
        check("R2", "still clearing", init_pull, 1'b1);
        cur_tag = "R11";
        tick(0, 0, 1);
        tick(1, 0, 0);
        cur_tag = "R4";
        idle(1);
        check("R3", "pull released in wait", init_pull, 1'b0);
        cur_tag = "R5";
        idle(4);
        tick(0, 1, 0);
        idle(1);
        check("R10", "released oe", cfg_oe, 1'b0);
        check("R10", "released lo_n", cfg_lo_n, 1'b1);
        cur_tag = "R10";
        tick(0, 0, 1);
        tick(0, 1, 0);
        idle(2);
        check("R10", "user ignores err", init_pull, 1'b0);

        // --- external hold in wait ---
        do_reset(1'b0);
        ext_hold = 1'b1;
        cur_tag = "R3";
        idle(STAB + 1);
        tick(1, 0, 0);
        for (int i = 0; i < 6; i++) tick(0, 1, 0);
        check("R3", "held wait flags driven", cfg_oe, 1'b1);
        ext_hold = 1'b0;
        cur_tag = "R4";
        idle(3);
        tick(0, 1, 0);
        idle(1);
        check("R5", "slave loads after release", cfg_oe, 1'b0);

        // --- master delay, completion during delay ignored ---
        do_reset(1'b1);
        cur_tag = "R6";
        idle(STAB + 1);
        tick(1, 0, 0);
        idle(4);
        for (int i = 0; i < DELAY - 3; i++) tick(0, 1, 0);
        check("R6", "delay ignores done", cfg_oe, 1'b1);
        idle(4);
        tick(0, 1, 0);
        idle(1);
        check("R6", "master reaches user", cfg_oe, 1'b0);

        // --- master delay interrupted by external hold ---
        do_reset(1'b1);
        cur_tag = "R7";
        idle(STAB + 1);
        tick(1, 0, 0);
        idle(3 + DELAY - 4);
        ext_hold = 1'b1;
        idle(4);
        ext_hold = 1'b0;
        idle(3 + DELAY - 2);
        tick(0, 1, 0);
        idle(1);
        check("R7", "restart blocks early load", cfg_oe, 1'b1);
        idle(3);
        tick(0, 1, 0);
        idle(1);
        check("R7", "loads after full delay", cfg_oe, 1'b0);

        // --- error during loading is sticky ---
        do_reset(1'b0);
        cur_tag = "R8";
        idle(STAB + 1);
        tick(1, 0, 0);
        idle(5);
        tick(0, 0, 1);
        idle(1);
        check("R8", "error pulls init", init_pull, 1'b1);
        tick(0, 1, 0);
        idle(3);
        check("R8", "error sticky oe", cfg_oe, 1'b1);

        // --- error and completion in the same cycle ---
        do_reset(1'b0);
        cur_tag = "R9";
        idle(STAB + 1);
        tick(1, 0, 0);
        idle(5);
        tick(0, 1, 1);
        idle(1);
        check("R9", "error wins pull", init_pull, 1'b1);
        check("R9", "error wins oe", cfg_oe, 1'b1);
        tick(0, 1, 0);
        idle(2);

        // --- error outside loading ignored ---
        do_reset(1'b0);
        ext_hold = 1'b1;
        cur_tag = "R11";
        idle(STAB + 1);
        tick(1, 0, 0);
        tick(0, 0, 1);
        idle(2);
        check("R11", "err in wait ignored", init_pull, 1'b0);
        ext_hold = 1'b0;
        idle(4);
        tick(0, 1, 0);
        idle(1);
        check("R11", "completes after ignored err", cfg_oe, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule